// File: doc/BRIEF.md
# Register Write Guard with Software Key Lock and Claim Tags

This block sits in front of the register file of a debug component and decides whether each bus write may land. Software-origin writes are blocked until an exact 32-bit key is written to the key address. Any other value written there re-arms the lock. Accesses marked as coming from an external debugger ignore the lock completely. The block drives a write-permit strobe that the surrounding register file uses to qualify its own write enables.

The block also holds a small claim tag. Software and debuggers use it to agree on who owns the component. The tag has one address that sets bits and another that clears them. Reads of the set address return the mask of implemented bits. Reads of the clear address return the current tag value.

The bus is a plain single-cycle register port with no handshake. A write is taken in the cycle in which `bus_we` is high. Read data is combinational from the address and the debugger flag. Because there is no data stream, no valid/ready back-pressure applies.

Top module: `regguard_top`

## Requirements
- R1: After reset, the lock status word at offset 0xFB4 reads 0x3: bit 0 (lock present) = 1, bit 1 (locked) = 1, bit 2 (lock type, 0 = 32-bit key register) = 0. The claim tag is 0.
- R2: A software-origin write of 0xC5ACCE55 to offset 0xFB0 unlocks. From the next cycle, lock status bit 1 reads 0.
- R3: A software-origin write of any other value to 0xFB0 locks again. From the next cycle, lock status bit 1 reads 1.
- R4: While locked, a software-origin write to any offset other than 0xFB0 leaves `wr_permit` low in that cycle, and the claim tag is not changed. While unlocked, such a write drives `wr_permit` high.
- R5: A write with `bus_dbg` = 1 drives `wr_permit` high whatever the lock state. It also updates the claim tag while the lock is set.
- R6: A read with `bus_dbg` = 1 returns 0 in lock status bits 0 and 1.
- R7: A permitted write to 0xFA0 sets every tag bit whose data bit is 1. Reading 0xFA0 returns 0xF, the implemented-bit mask.
- R8: A permitted write to 0xFA4 clears every tag bit whose data bit is 1. Reading 0xFA4 returns the current tag.
- R9: Data bits that are 0 in a claim write leave the matching tag bits unchanged.
- R10: A write to 0xFB0 never asserts `wr_permit`. A write from the debugger to 0xFB0 does not change the lock state.
- R11: `hit` is high only for the four offsets 0xFA0, 0xFA4, 0xFB0 and 0xFB4. `rd_data` is 0 for any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte offset within the component window |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_dbg | input | 1 | Access originates from an external debugger |
| rd_data | output | 32 | Read data for the guard's own registers |
| hit | output | 1 | The address belongs to this block |
| wr_permit | output | 1 | Write may be applied to the protected register file |
| claim_tag | output | 4 | Current claim tag |

## Verification
The lock is exercised with three kinds of key-register write: the exact key, a value that differs from the key in one bit, and zero. Only the first may unlock, and this separates a full 32-bit comparison from a partial one.

Protected writes are issued with each combination of origin and lock state. This shows that the debugger bypass and the key lock are separate conditions.

Claim writes use overlapping masks (0x5 then 0x6 for set, 0x4 for clear). These show that zero bits preserve the tag and that setting accumulates rather than overwrites. Status reads are repeated with the debugger flag both low and high, to expose the masking of bits 0 and 1.

// File: rtl/regguard_pkg.sv
package regguard_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFF_CLAIM_SET = 12'hFA0;
  localparam logic [ADDR_W-1:0] OFF_CLAIM_CLR = 12'hFA4;
  localparam logic [ADDR_W-1:0] OFF_KEY       = 12'hFB0;
  localparam logic [ADDR_W-1:0] OFF_LSTAT     = 12'hFB4;
  localparam logic [DATA_W-1:0] UNLOCK_KEY    = 32'hC5AC_CE55;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CSET, SEL_CCLR, SEL_KEY, SEL_LSTAT
  } sel_e;
endpackage

// File: rtl/regguard_decode.sv
module regguard_decode
  import regguard_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel
);
  always_comb begin
    unique case (addr)
      OFF_CLAIM_SET: sel = SEL_CSET;
      OFF_CLAIM_CLR: sel = SEL_CCLR;
      OFF_KEY:       sel = SEL_KEY;
      OFF_LSTAT:     sel = SEL_LSTAT;
      default:       sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/regguard_lock.sv
module regguard_lock
  import regguard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              dbg,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked,
  output logic              permit
);
  logic key_wr;
  assign key_wr = we && !dbg && (sel == SEL_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      locked <= 1'b1;
    else if (key_wr) locked <= (wdata != UNLOCK_KEY);
  end

  assign permit = we && (sel != SEL_KEY) && (dbg || !locked);

  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata == UNLOCK_KEY) |=> !locked); // R2
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && wdata != UNLOCK_KEY) |=> locked); // R3
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !dbg) |-> !permit); // R4
  AST_DBG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dbg && sel != SEL_KEY) |-> permit); // R5
  AST_DBG_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (we && dbg && sel == SEL_KEY) |=> $stable(locked)); // R10
endmodule

// File: rtl/regguard_claim.sv
module regguard_claim
  import regguard_pkg::*;
#(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             permit,
  input  sel_e             sel,
  input  logic [TAG_W-1:0] wbits,
  output logic [TAG_W-1:0] tag
);
  logic [TAG_W-1:0] tag_nxt;

  always_comb begin
    tag_nxt = tag;
    if (permit && sel == SEL_CSET) tag_nxt = tag | wbits;
    if (permit && sel == SEL_CCLR) tag_nxt = tag & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag <= '0;
    else        tag <= tag_nxt;
  end

  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !permit |=> $stable(tag)); // R4
  AST_SET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && sel == SEL_CSET) |=> ((tag & $past(tag)) == $past(tag))); // R9
  AST_CLR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (permit && sel == SEL_CCLR) |=> ((tag & ~$past(tag)) == '0)); // R9
endmodule

// File: rtl/regguard_top.sv
module regguard_top
  import regguard_pkg::*;
#(
  parameter int unsigned TAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_dbg,
  output logic [DATA_W-1:0] rd_data,
  output logic              hit,
  output logic              wr_permit,
  output logic [TAG_W-1:0]  claim_tag
);
  localparam logic [TAG_W-1:0] TAG_MASK = {TAG_W{1'b1}};

  sel_e sel;
  logic locked;

  regguard_decode u_dec (.addr(bus_addr), .sel(sel));

  regguard_lock u_lock (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .dbg(bus_dbg), .sel(sel),
    .wdata(bus_wdata), .locked(locked), .permit(wr_permit)
  );

  regguard_claim #(.TAG_W(TAG_W)) u_claim (
    .clk(clk), .rst_n(rst_n), .permit(wr_permit), .sel(sel),
    .wbits(bus_wdata[TAG_W-1:0]), .tag(claim_tag)
  );

  assign hit = (sel != SEL_NONE);

  always_comb begin
    rd_data = '0;
    unique case (sel)
      SEL_CSET:  rd_data[TAG_W-1:0] = TAG_MASK;
      SEL_CCLR:  rd_data[TAG_W-1:0] = claim_tag;
      SEL_LSTAT: rd_data[2:0] = bus_dbg ? 3'b000 : {1'b0, locked, 1'b1};
      default:   rd_data = '0;
    endcase
  end

  AST_DBG_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dbg && sel == SEL_LSTAT) |-> (rd_data[1:0] == 2'b00)); // R6
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rd_data == '0)); // R11
endmodule

// File: tb/regguard_top_tb_top.sv
module regguard_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_dbg = 1'b0;
  logic [31:0] rd_data;
  logic        hit, wr_permit;
  logic [3:0]  claim_tag;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  regguard_top dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive at negedge; write takes effect at the following posedge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic dbg,
                    input logic exp_perm, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_dbg = dbg;
    #1 check(req, {31'd0, wr_permit}, {31'd0, exp_perm});
    @(negedge clk);
    bus_we = 1'b0; bus_dbg = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic dbg, input logic [31:0] exp,
                    input string req);
    @(negedge clk);
    bus_addr = a; bus_dbg = dbg; bus_we = 1'b0;
    #1 check(req, rd_data, exp);
    bus_dbg = 1'b0;
  endtask

  task automatic t_reset;
    rd(12'hFB4, 1'b0, 32'h3, "R1");
    rd(12'hFA4, 1'b0, 32'h0, "R1");
  endtask

  task automatic t_lock_blocks;
    wr(12'h010, 32'h1, 1'b0, 1'b0, "R4");
    wr(12'hFA0, 32'hF, 1'b0, 1'b0, "R4");
    rd(12'hFA4, 1'b0, 32'h0, "R4");
  endtask

  task automatic t_dbg;
    wr(12'h010, 32'h1, 1'b1, 1'b1, "R5");
    wr(12'hFA0, 32'h8, 1'b1, 1'b1, "R5");
    rd(12'hFA4, 1'b0, 32'h8, "R5");
    rd(12'hFB4, 1'b1, 32'h0, "R6");
    wr(12'hFB0, 32'hC5ACCE55, 1'b1, 1'b0, "R10");
    rd(12'hFB4, 1'b0, 32'h3, "R10");
    wr(12'hFA4, 32'h8, 1'b1, 1'b1, "R5");
  endtask

  task automatic t_keys;
    wr(12'hFB0, 32'hC5ACCE54, 1'b0, 1'b0, "R3");
    rd(12'hFB4, 1'b0, 32'h3, "R3");
    wr(12'hFB0, 32'hC5ACCE55, 1'b0, 1'b0, "R10");
    rd(12'hFB4, 1'b0, 32'h1, "R2");
    rd(12'hFB4, 1'b1, 32'h0, "R6");
    wr(12'h010, 32'h1, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_claim;
    rd(12'hFA0, 1'b0, 32'hF, "R7");
    wr(12'hFA0, 32'h5, 1'b0, 1'b1, "R7");
    rd(12'hFA4, 1'b0, 32'h5, "R7");
    wr(12'hFA0, 32'h6, 1'b0, 1'b1, "R9");
    rd(12'hFA4, 1'b0, 32'h7, "R9");
    wr(12'hFA4, 32'h4, 1'b0, 1'b1, "R8");
    rd(12'hFA4, 1'b0, 32'h3, "R8");
    check("R8", {28'd0, claim_tag}, 32'h3);
  endtask

  task automatic t_relock;
    wr(12'hFB0, 32'h0, 1'b0, 1'b0, "R3");
    rd(12'hFB4, 1'b0, 32'h3, "R3");
    wr(12'hFA4, 32'hF, 1'b0, 1'b0, "R4");
    rd(12'hFA4, 1'b0, 32'h3, "R4");
  endtask

  task automatic t_decode;
    rd(12'h123, 1'b0, 32'h0, "R11");
    check("R11", {31'd0, hit}, 32'h0);
    rd(12'hFB4, 1'b0, 32'h3, "R11");
    check("R11", {31'd0, hit}, 32'h1);
  endtask

  initial begin
    fork
      begin
        #1000;
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_lock_blocks();
        t_dbg();
        t_keys();
        t_claim();
        t_relock();
        t_decode();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule